// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block is the receiving end of an audio serial link. It runs as a slave to an external bit clock and to a word-select or frame-sync line. It brings both lines, together with the serial data line, into the system clock domain. It finds the capture edges of the bit clock and cuts the bit stream into audio words. Each word leaves on a parallel output with a valid/ready handshake, tagged with the index of the channel it belongs to.

Five framings are selected at run time:
- two-channel framing with a one-bit delay after each word-select change;
- left-aligned framing;
- right-aligned framing;
- short-sync multi-word framing;
- long-sync multi-word framing.

Further settings cover the word size, the number of words in a multi-word frame, the bit order, and the polarity of each external clock line. Received words are two's complement. A word narrower than the output bus is sign-extended. When a finished word finds the previous one still waiting for acceptance, the block replaces it and raises a one-cycle overrun pulse.

Top module: `audio_rx_deser`

## Requirements
- R1: Format code 0 (two-channel, delayed): the bit captured at a word-select change is discarded, and the next `cfgWordBits` bits form the word. The channel is the sampled word-select level (0 = channel 0, 1 = channel 1).
- R2: Format code 3 (left-aligned): the bit captured at a word-select change is the first bit of the word. Word-select 1 gives channel 0 and word-select 0 gives channel 1.
- R3: Format code 4 (right-aligned): when word-select changes, the last `cfgWordBits` bits captured before the change form the word of the slot that just ended (level 1 gives channel 0, level 0 gives channel 1). The first change after reset only arms this mode.
- R4: Format code 1 (short sync): a bit sampled with the sync high, followed by a bit sampled with it low, starts a word at that low bit. Further words follow back to back with channel 0, 1 and so on, until `cfgChannels` words are done.
- R5: Format code 2 (long sync): the first bit sampled with the sync high starts word 0. The sync length has no other effect, and the following words are contiguous as in R4.
- R6: In format code 0 the frame always carries exactly two words with channel 0 or 1, whatever `cfgChannels` holds.
- R7: With `cfgLsbFirst` = 1 the first captured bit of a word is its least significant bit; otherwise it is the most significant bit.
- R8: Words are two's complement. Bit `cfgWordBits`-1 is copied into every higher bit of `outData`.
- R9: Format codes 0, 3 and 4 capture on the rising bit-clock edge, and codes 1 and 2 capture on the falling edge. `cfgBclkInv` = 1 swaps the capture edge, and `cfgWsInv` = 1 inverts word-select before any decoding.
- R10: Once `outValid` is high it stays high, with `outData` and `outChan` unchanged, until a cycle in which `outReady` is high, unless an overrun replaces the word.
- R11: A word that completes while `outValid` is high and `outReady` is low replaces the held word. `overrun` goes high for exactly one cycle, at the moment the new word appears.
- R12: While `rstN` is low, and in the first cycle after it rises, `outValid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclkIn | input | 1 | External bit clock |
| wsIn | input | 1 | External word-select or frame-sync |
| sdIn | input | 1 | External serial data |
| cfgFormat | input | 3 | Framing code (0 two-channel delayed, 1 short sync, 2 long sync, 3 left-aligned, 4 right-aligned) |
| cfgWordBits | input | $clog2(MAX_BITS+1) | Bits per word, 2 to MAX_BITS |
| cfgChannels | input | $clog2(MAX_CH+1) | Words per multi-word frame, 1 to MAX_CH |
| cfgLsbFirst | input | 1 | 1: least significant bit arrives first |
| cfgBclkInv | input | 1 | Swap the bit-clock capture edge |
| cfgWsInv | input | 1 | Invert word-select before decoding |
| outData | output | OUT_W | Sign-extended received word |
| outChan | output | $clog2(MAX_CH) | Channel index of outData |
| outValid | output | 1 | A word is held on outData |
| outReady | input | 1 | Consumer accepts the held word |
| overrun | output | 1 | One-cycle pulse when a held word is replaced |

## Verification
Every framing is driven with slots whose unused bits are ones. If a discarded or padding bit were taken into a word, the result would visibly change. The word values use both signs and asymmetric bit patterns, so that a shift of one position, a reversed bit order or a missing sign extension each give a different result. Multi-word frames check the channel count and the contiguous channel numbering. A run with the channel count set to one checks that the two-channel framing ignores that setting. A polarity-inverted run must decode the same words as the plain one. A run with the consumer stalled separates word replacement, and the single overrun pulse, from a simple loss of the held word.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S       = 3'd0,
    FMT_SYNC_SHORT = 3'd1,
    FMT_SYNC_LONG  = 3'd2,
    FMT_LEFT      = 3'd3,
    FMT_RIGHT     = 3'd4
  } fmtE;

  // Per capture-edge commands from control to datapath
  typedef struct packed {
    logic shift;    // take the current serial bit into the shift register
    logic emit;     // a word is complete in this cycle
    logic emitCur;  // the completed word includes the current bit
  } strobeT;

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bclkIn,
  input  logic wsIn,
  input  logic sdIn,
  output logic wsS,
  output logic sdS,
  output logic bclkRise,
  output logic bclkFall
);

  localparam int LINES = 3;

  logic [LINES-1:0] chain [STAGES];
  logic             bclkD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      bclkD <= 1'b0;
    end else begin
      chain[0] <= {bclkIn, wsIn, sdIn};
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      bclkD <= chain[STAGES-1][2];
    end
  end

  assign wsS      = chain[STAGES-1][1];
  assign sdS      = chain[STAGES-1][0];
  assign bclkRise = chain[STAGES-1][2] & ~bclkD;
  assign bclkFall = ~chain[STAGES-1][2] & bclkD;

endmodule

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
#(
  parameter int WB_W   = 6,
  parameter int CNT_W  = 4,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkRise,
  input  logic              bclkFall,
  input  logic              wsS,
  input  logic [2:0]        cfgFormat,
  input  logic [WB_W-1:0]   cfgWordBits,
  input  logic [CNT_W-1:0]  cfgChannels,
  input  logic              cfgBclkInv,
  input  logic              cfgWsInv,
  output strobeT            strobe,
  output logic [CHAN_W-1:0] emitChan
);

  fmtE               fmt;
  logic              isSync, wordFmt, capEdge, wsBit, wsChg;
  logic              wsKnown, wsPrev, armed, active, rjLocked;
  logic [WB_W-1:0]   bitCnt, idx, lastIdx;
  logic [CHAN_W-1:0] chan, chanUse, startChan;
  logic              start, take, lastBit, moreCh, rjEmit;

  always_comb begin
    fmt     = fmtE'(cfgFormat);
    isSync  = (fmt == FMT_SYNC_SHORT) || (fmt == FMT_SYNC_LONG);
    wordFmt = (fmt == FMT_I2S) || (fmt == FMT_LEFT) || isSync;
    capEdge = (isSync ^ cfgBclkInv) ? bclkFall : bclkRise;
    wsBit   = wsS ^ cfgWsInv;
    wsChg   = wsKnown && (wsBit != wsPrev);
    lastIdx = cfgWordBits - WB_W'(1);

    start     = 1'b0;
    startChan = '0;
    unique case (fmt)
      FMT_I2S: begin
        start     = armed && !wsChg;
        startChan = chan;
      end
      FMT_LEFT: begin
        start     = wsChg;
        startChan = CHAN_W'(!wsBit);
      end
      FMT_SYNC_SHORT: start = wsKnown && wsPrev && !wsBit;
      FMT_SYNC_LONG:  start = wsKnown && !wsPrev && wsBit;
      default:        start = 1'b0;
    endcase

    take    = capEdge && wordFmt &&
              (start || (active && !(wsChg && fmt == FMT_I2S)));
    idx     = start ? '0 : bitCnt;
    chanUse = start ? startChan : chan;
    lastBit = (idx == lastIdx);
    moreCh  = isSync && ((CNT_W'(chanUse) + CNT_W'(1)) < cfgChannels);
    rjEmit  = capEdge && (fmt == FMT_RIGHT) && wsChg && rjLocked;

    strobe.shift   = take || (capEdge && fmt == FMT_RIGHT);
    strobe.emit    = (take && lastBit) || rjEmit;
    strobe.emitCur = take;
    emitChan       = rjEmit ? CHAN_W'(!wsPrev) : chanUse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsKnown  <= 1'b0;
      wsPrev   <= 1'b0;
      armed    <= 1'b0;
      active   <= 1'b0;
      rjLocked <= 1'b0;
      bitCnt   <= '0;
      chan     <= '0;
    end else if (capEdge) begin
      wsPrev  <= wsBit;
      wsKnown <= 1'b1;
      if (fmt == FMT_RIGHT && wsChg) rjLocked <= 1'b1;
      if (fmt == FMT_I2S && wsChg) begin
        armed  <= 1'b1;
        active <= 1'b0;
        chan   <= CHAN_W'(wsBit);
      end else if (take) begin
        armed <= 1'b0;
        if (lastBit) begin
          active <= moreCh;
          bitCnt <= '0;
          chan   <= moreCh ? chanUse + CHAN_W'(1) : chanUse;
        end else begin
          active <= 1'b1;
          bitCnt <= idx + WB_W'(1);
          chan   <= chanUse;
        end
      end
    end
  end

endmodule

// File: rtl/audio_rx_dp.sv
module audio_rx_dp
  import audio_rx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int OUT_W    = 32,
  parameter int WB_W     = 6,
  parameter int CHAN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [CHAN_W-1:0] emitChan,
  input  logic              sdS,
  input  logic [WB_W-1:0]   cfgWordBits,
  input  logic              cfgLsbFirst,
  input  logic              outReady,
  output logic [OUT_W-1:0]  outData,
  output logic [CHAN_W-1:0] outChan,
  output logic              outValid,
  output logic              overrun
);

  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [MAX_BITS-1:0] shreg, nextSh, word, rev, ordered;
  logic [OUT_W-1:0]    ext;
  logic                signBit;

  always_comb begin
    nextSh = {shreg[MAX_BITS-2:0], sdS};
    word   = strobe.emitCur ? nextSh : shreg;
    for (int j = 0; j < MAX_BITS; j++) rev[j] = word[MAX_BITS-1-j];
    ordered = cfgLsbFirst ? (rev >> (MAX_BITS - int'(cfgWordBits))) : word;
    signBit = ordered[IDX_W'(cfgWordBits - WB_W'(1))];
  end

  for (genvar i = 0; i < OUT_W; i++) begin : gExt
    if (i < MAX_BITS) begin : gIn
      assign ext[i] = (WB_W'(i) < cfgWordBits) ? ordered[i] : signBit;
    end else begin : gTop
      assign ext[i] = signBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg    <= '0;
      outData  <= '0;
      outChan  <= '0;
      outValid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (strobe.shift) shreg <= nextSh;
      if (strobe.emit) begin
        outData  <= ext;
        outChan  <= emitChan;
        outValid <= 1'b1;
        overrun  <= outValid && !outReady;
      end else begin
        overrun <= 1'b0;
        if (outReady) outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser
  import audio_rx_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int OUT_W       = 32,
  parameter int MAX_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WB_W   = $clog2(MAX_BITS + 1),
  localparam int CNT_W  = $clog2(MAX_CH + 1),
  localparam int CHAN_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              wsIn,
  input  logic              sdIn,
  input  logic [2:0]        cfgFormat,
  input  logic [WB_W-1:0]   cfgWordBits,
  input  logic [CNT_W-1:0]  cfgChannels,
  input  logic              cfgLsbFirst,
  input  logic              cfgBclkInv,
  input  logic              cfgWsInv,
  output logic [OUT_W-1:0]  outData,
  output logic [CHAN_W-1:0] outChan,
  output logic              outValid,
  input  logic              outReady,
  output logic              overrun
);

  logic              wsS, sdS, bclkRise, bclkFall;
  strobeT            strobe;
  logic [CHAN_W-1:0] emitChan;

  audio_rx_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .wsIn(wsIn), .sdIn(sdIn),
    .wsS(wsS), .sdS(sdS), .bclkRise(bclkRise), .bclkFall(bclkFall)
  );

  audio_rx_ctrl #(.WB_W(WB_W), .CNT_W(CNT_W), .CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bclkRise(bclkRise), .bclkFall(bclkFall),
    .wsS(wsS), .cfgFormat(cfgFormat), .cfgWordBits(cfgWordBits),
    .cfgChannels(cfgChannels), .cfgBclkInv(cfgBclkInv), .cfgWsInv(cfgWsInv),
    .strobe(strobe), .emitChan(emitChan)
  );

  audio_rx_dp #(.MAX_BITS(MAX_BITS), .OUT_W(OUT_W), .WB_W(WB_W), .CHAN_W(CHAN_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .emitChan(emitChan), .sdS(sdS),
    .cfgWordBits(cfgWordBits), .cfgLsbFirst(cfgLsbFirst), .outReady(outReady),
    .outData(outData), .outChan(outChan), .outValid(outValid), .overrun(overrun)
  );

endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk #(
  parameter int OUT_W  = 32,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cfgFormat,
  input logic              outReady,
  input logic              outValid,
  input logic [OUT_W-1:0]  outData,
  input logic [CHAN_W-1:0] outChan,
  input logic              overrun
);

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> (overrun || ($stable(outData) && $stable(outChan))));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> !overrun);

  a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> outValid && $past(outValid && !outReady));

  a_r6_two_channels: assert property (@(posedge clk) disable iff (!rstN)
    outValid && cfgFormat == 3'd0 |-> outChan <= CHAN_W'(1));

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid && !overrun);

endmodule

bind audio_rx_deser audio_rx_chk #(.OUT_W(OUT_W), .CHAN_W(CHAN_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgFormat(cfgFormat), .outReady(outReady),
  .outValid(outValid), .outData(outData), .outChan(outChan), .overrun(overrun)
);

// File: tb/tb_audio_rx_deser.sv
module tb_audio_rx_deser;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic [2:0]  cfgFormat = 3'd0;
  logic [5:0]  cfgWordBits = 6'd16;
  logic [3:0]  cfgChannels = 4'd2;
  logic        cfgLsbFirst = 1'b0, cfgBclkInv = 1'b0, cfgWsInv = 1'b0;
  logic [31:0] outData;
  logic [2:0]  outChan;
  logic        outValid, overrun;
  logic        outReady = 1'b1;

  int checks = 0, failures = 0, ovCnt = 0;
  logic [34:0] gotQ[$];
  logic capRise = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_rx_deser dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .wsIn(wsIn), .sdIn(sdIn),
    .cfgFormat(cfgFormat), .cfgWordBits(cfgWordBits), .cfgChannels(cfgChannels),
    .cfgLsbFirst(cfgLsbFirst), .cfgBclkInv(cfgBclkInv), .cfgWsInv(cfgWsInv),
    .outData(outData), .outChan(outChan), .outValid(outValid),
    .outReady(outReady), .overrun(overrun)
  );

  always @(negedge clk) if (rstN) begin
    if (outValid && outReady) gotQ.push_back({outChan, outData});
    if (overrun) ovCnt++;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] sx(logic [31:0] v, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  task automatic startTest(logic [2:0] fmt, int bits, int ch, logic lsb, logic bInv, logic wInv);
    rstN = 1'b0;
    cfgFormat = fmt; cfgWordBits = 6'(bits); cfgChannels = 4'(ch);
    cfgLsbFirst = lsb; cfgBclkInv = bInv; cfgWsInv = wInv;
    capRise = !(fmt == 3'd1 || fmt == 3'd2) ^ bInv;
    bclkIn = capRise ? 1'b0 : 1'b1;
    wsIn = wInv; sdIn = 1'b0; outReady = 1'b1;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    gotQ.delete();
    ovCnt = 0;
  endtask

  task automatic sendBit(logic ws, logic sd);
    bclkIn = capRise ? 1'b0 : 1'b1;
    wsIn = ws ^ cfgWsInv;
    sdIn = sd;
    waitCyc(HALF_BIT);
    bclkIn = ~bclkIn;
    waitCyc(HALF_BIT);
  endtask

  function automatic logic wordBit(logic [31:0] v, int n, int i);
    return cfgLsbFirst ? v[i] : v[n-1-i];
  endfunction

  // slot of s bits, word at offset off, all other bits driven to 1
  task automatic sendSlot(logic ws, logic [31:0] v, int n, int s, int off);
    for (int i = 0; i < s; i++) begin
      if (i >= off && i < off + n) sendBit(ws, wordBit(v, n, i - off));
      else sendBit(ws, 1'b1);
    end
  endtask

  task automatic sendWord(logic [31:0] v, int n, int wsHigh);
    for (int i = 0; i < n; i++) sendBit(i < wsHigh, wordBit(v, n, i));
  endtask

  task automatic expWord(string req, int idx, int ch, logic [31:0] v);
    if (idx < gotQ.size()) begin
      check({req, " chan"}, 64'(gotQ[idx][34:32]), 64'(ch));
      check({req, " data"}, 64'(gotQ[idx][31:0]), 64'(v));
    end else check({req, " missing word"}, 64'(gotQ.size()), 64'(idx + 1));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    waitCyc(2);
    check("R12 valid in reset", 64'(outValid), 64'd0);
    check("R12 overrun in reset", 64'(overrun), 64'd0);
  endtask

  // R1, R6, R8: two-channel delayed framing with channel count set to 1
  task automatic testI2s();
    startTest(3'd0, 16, 1, 1'b0, 1'b0, 1'b0);
    sendSlot(1'b1, 32'h0, 16, 20, 20);
    sendSlot(1'b0, 32'h1234, 16, 20, 1);
    sendSlot(1'b1, 32'h8001, 16, 20, 1);
    waitCyc(12);
    check("R6 word count", 64'(gotQ.size()), 64'd2);
    expWord("R1 left", 0, 0, 32'h0000_1234);
    expWord("R8 right sign", 1, 1, 32'hFFFF_8001);
  endtask

  // R2, R8: left-aligned, 24-bit words
  task automatic testLeft();
    startTest(3'd3, 24, 2, 1'b0, 1'b0, 1'b0);
    sendSlot(1'b0, 32'h0, 24, 26, 26);
    sendSlot(1'b1, 32'h5A5A5A, 24, 26, 0);
    sendSlot(1'b0, 32'h800000, 24, 26, 0);
    waitCyc(12);
    check("R2 word count", 64'(gotQ.size()), 64'd2);
    expWord("R2 left", 0, 0, 32'h005A_5A5A);
    expWord("R8 right 24b", 1, 1, 32'hFF80_0000);
  endtask

  // R3: right-aligned, 16-bit words in 24-bit slots
  task automatic testRight();
    startTest(3'd4, 16, 2, 1'b0, 1'b0, 1'b0);
    sendSlot(1'b0, 32'h0, 16, 24, 24);
    sendSlot(1'b1, 32'h0F0F, 16, 24, 8);
    sendSlot(1'b0, 32'hF00F, 16, 24, 8);
    sendBit(1'b1, 1'b1);
    waitCyc(12);
    check("R3 word count", 64'(gotQ.size()), 64'd2);
    expWord("R3 left", 0, 0, 32'h0000_0F0F);
    expWord("R3 right", 1, 1, 32'hFFFF_F00F);
  endtask

  // R4: short sync, three contiguous words
  task automatic testShort(logic bInv);
    startTest(3'd1, 16, 3, 1'b0, bInv, 1'b0);
    sendBit(1'b0, 1'b1); sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    sendWord(32'h1111, 16, 0);
    sendWord(32'h2222, 16, 0);
    sendWord(32'hC003, 16, 0);
    sendBit(1'b0, 1'b1); sendBit(1'b0, 1'b1);
    waitCyc(12);
    check("R4 word count", 64'(gotQ.size()), 64'd3);
    expWord("R4 word0", 0, 0, 32'h0000_1111);
    expWord("R4 word1", 1, 1, 32'h0000_2222);
    expWord("R4 word2", 2, 2, 32'hFFFF_C003);
  endtask

  // R5: long sync of three bits, two 12-bit words
  task automatic testLong();
    startTest(3'd2, 12, 2, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b1); sendBit(1'b0, 1'b1);
    sendWord(32'h123, 12, 3);
    sendWord(32'h800, 12, 0);
    sendBit(1'b0, 1'b1); sendBit(1'b0, 1'b1);
    waitCyc(12);
    check("R5 word count", 64'(gotQ.size()), 64'd2);
    expWord("R5 word0", 0, 0, 32'h0000_0123);
    expWord("R5 word1", 1, 1, 32'hFFFF_F800);
  endtask

  // R7: least significant bit first
  task automatic testLsbFirst();
    startTest(3'd0, 16, 2, 1'b1, 1'b0, 1'b0);
    sendSlot(1'b1, 32'h0, 16, 20, 20);
    sendSlot(1'b0, 32'h00A5, 16, 20, 1);
    sendSlot(1'b1, 32'h7001, 16, 20, 1);
    waitCyc(12);
    check("R7 word count", 64'(gotQ.size()), 64'd2);
    expWord("R7 left", 0, 0, 32'h0000_00A5);
    expWord("R7 right", 1, 1, 32'h0000_7001);
  endtask

  // R9: both polarities inverted on left-aligned framing
  task automatic testInvert();
    startTest(3'd3, 16, 2, 1'b0, 1'b1, 1'b1);
    sendSlot(1'b0, 32'h0, 16, 18, 18);
    sendSlot(1'b1, 32'h4321, 16, 18, 0);
    sendSlot(1'b0, 32'h9ABC, 16, 18, 0);
    waitCyc(12);
    check("R9 word count", 64'(gotQ.size()), 64'd2);
    expWord("R9 left", 0, 0, 32'h0000_4321);
    expWord("R9 right", 1, 1, 32'hFFFF_9ABC);
  endtask

  // R10, R11: stalled consumer
  task automatic testOverrun();
    logic [31:0] held;
    startTest(3'd3, 16, 2, 1'b0, 1'b0, 1'b0);
    outReady = 1'b0;
    sendSlot(1'b0, 32'h0, 16, 18, 18);
    sendSlot(1'b1, 32'h1357, 16, 18, 0);
    waitCyc(6);
    check("R10 valid held", 64'(outValid), 64'd1);
    check("R10 first word held", 64'(outData), 64'h1357);
    sendSlot(1'b0, 32'h2468, 16, 18, 0);
    waitCyc(6);
    check("R11 pulse count", 64'(ovCnt), 64'd1);
    check("R11 replaced data", 64'(outData), 64'h2468);
    check("R11 replaced chan", 64'(outChan), 64'd1);
    held = outData;
    waitCyc(8);
    check("R10 data stable", 64'(outData), 64'(held));
    check("R10 still valid", 64'(outValid), 64'd1);
    outReady = 1'b1;
    waitCyc(1);
    check("R10 released", 64'(outValid), 64'd0);
    check("R11 one delivery", 64'(gotQ.size()), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R12 valid after release", 64'(outValid), 64'd0);
    testI2s();
    testLeft();
    testRight();
    testShort(1'b0);
    testShort(1'b1);
    testLong();
    testLsbFirst();
    testInvert();
    testOverrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule